// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is an integer multiplier with a 64-bit accumulator. The accumulator is stored as two 32-bit registers: HI holds the upper half and LO holds the lower half. Each request carries two 32-bit operands and a 4-bit select. The unit forms a signed or unsigned 64-bit product. It then does one of four things: loads the product, loads the negated product, adds the product to the accumulator, or subtracts the product from it. The new value is written back to HI/LO. One half of the new value is returned as the destination result, and a one-cycle done pulse marks it.

The select combines a 3-bit operation kind with an unsigned flag, which gives fourteen legal codes. The kind also decides which half is returned. Software-visible copies of HI and LO are always driven on read ports. Direct write enables can load either register. All arithmetic wraps modulo 2^64 and overflow is never reported.

Top module: `hilo_mac_unit`

## Requirements
- R1: A synchronous active-high reset clears HI and LO to zero and holds `res_done` and `res_illegal` low.
- R2: `op_sel[0]`=1 zero-extends both operands before multiplying. `op_sel[0]`=0 sign-extends them. The product is 64 bits.
- R3: Kinds 0 and 4 (`op_sel[3:1]`) load HI/LO with zero minus the product, modulo 2^64. This applies to both signed and unsigned forms.
- R4: Kinds 1 and 5 load HI/LO with the previous {HI,LO} plus the product.
- R5: Kinds 2 and 6 load HI/LO with the previous {HI,LO} minus the product.
- R6: Kind 3 loads HI/LO with the product alone.
- R7: Kinds 3, 4, 5 and 6 return the new HI on `res_data`. Kinds 0, 1 and 2 return the new LO.
- R8: `res_done` is high for exactly the cycle after each cycle in which `op_valid` is high. HI/LO and `res_data` are updated at that same edge. A request in the very next cycle uses the accumulator written by the previous one.
- R9: Kind 7 is reserved. It raises `res_illegal` together with `res_done`, drives `res_data` to zero, and leaves HI/LO unchanged. A direct write in the same cycle still takes effect.
- R10: `hi_we`/`lo_we` load the register from `hi_wdata`/`lo_wdata` at the next edge, and the read ports show the new value one cycle later. A legal request in the same cycle takes priority over both writes.
- R11: Results wrap modulo 2^64 with no overflow indication. For example, an accumulator of all ones plus a product of 1 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 4 | [3:1] kind, [0] unsigned |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| hi_we | input | 1 | Direct write enable for HI |
| hi_wdata | input | 32 | Direct write data for HI |
| lo_we | input | 1 | Direct write enable for LO |
| lo_wdata | input | 32 | Direct write data for LO |
| hi_rdata | output | 32 | Current HI |
| lo_rdata | output | 32 | Current LO |
| res_data | output | 32 | Destination result |
| res_done | output | 1 | Result valid pulse |
| res_illegal | output | 1 | Reserved kind was requested |

## Verification
The accumulator is fed back into every later accumulate or subtract, so a wrong HI or LO bit persists. It shows on the read ports at the done edge, and it spreads into every later accumulating result. The bench therefore compares both read ports as well as `res_data` on every done pulse. A wrong half select or a wrong extension shows on `res_data` in the very cycle the done pulse rises. Back-to-back chains catch a stale accumulator one request later.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_NEG_LO  = 3'd0,
        K_ACC_LO  = 3'd1,
        K_SUB_LO  = 3'd2,
        K_PROD_HI = 3'd3,
        K_NEG_HI  = 3'd4,
        K_ACC_HI  = 3'd5,
        K_SUB_HI  = 3'd6,
        K_RSVD    = 3'd7
    } kind_e;

    // Control word derived from the select field
    typedef struct packed {
        logic zero_ext;  // unsigned operands
        logic use_acc;   // start from current HI/LO instead of zero
        logic minus;     // subtract the product from the base
        logic ret_hi;    // return upper half
        logic illegal;   // reserved kind
    } ctrl_t;

    function automatic ctrl_t decode_sel(input logic [SEL_W-1:0] sel);
        ctrl_t c;
        c          = '0;
        c.zero_ext = sel[0];
        case (kind_e'(sel[SEL_W-1:1]))
            K_NEG_LO:  begin c.minus = 1'b1; end
            K_ACC_LO:  begin c.use_acc = 1'b1; end
            K_SUB_LO:  begin c.use_acc = 1'b1; c.minus = 1'b1; end
            K_PROD_HI: begin c.ret_hi = 1'b1; end
            K_NEG_HI:  begin c.minus = 1'b1; c.ret_hi = 1'b1; end
            K_ACC_HI:  begin c.use_acc = 1'b1; c.ret_hi = 1'b1; end
            K_SUB_HI:  begin c.use_acc = 1'b1; c.minus = 1'b1; c.ret_hi = 1'b1; end
            default:   begin c.illegal = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import hilo_mac_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output ctrl_t            ctrl
);
    always_comb begin
        ctrl = decode_sel(sel);
    end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   mul_a,
    input  logic [DATA_W-1:0]   mul_b,
    input  logic                zero_ext,
    output logic [2*DATA_W-1:0] product
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] ext_a;
    logic [PROD_W-1:0] ext_b;
    logic              fill_a;
    logic              fill_b;

    always_comb begin
        fill_a  = ~zero_ext & mul_a[DATA_W-1];
        fill_b  = ~zero_ext & mul_b[DATA_W-1];
        ext_a   = {{DATA_W{fill_a}}, mul_a};
        ext_b   = {{DATA_W{fill_b}}, mul_b};
        // Truncated 2W x 2W product is the correct 2W-bit result for both forms
        product = ext_a * ext_b;
    end
endmodule

// File: rtl/mac_combine.sv
module mac_combine
    import hilo_mac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] acc_now,
    input  logic [2*DATA_W-1:0] product,
    input  ctrl_t               ctrl,
    output logic [2*DATA_W-1:0] acc_next
);
    localparam int unsigned ACC_W = 2 * DATA_W;

    logic [ACC_W-1:0] base;

    always_comb begin
        base     = ctrl.use_acc ? acc_now : '0;
        acc_next = ctrl.minus ? (base - product) : (base + product);
    end
endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
    import hilo_mac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] lo_wdata,
    output logic [DATA_W-1:0] hi_rdata,
    output logic [DATA_W-1:0] lo_rdata,
    output logic [DATA_W-1:0] res_data,
    output logic              res_done,
    output logic              res_illegal
);
    localparam int unsigned ACC_W = 2 * DATA_W;

    ctrl_t             ctrl;
    logic [ACC_W-1:0]  product;
    logic [ACC_W-1:0]  acc_next;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] res_q;
    logic              done_q;
    logic              ill_q;
    logic              commit;

    mac_decode u_dec (
        .sel  (op_sel),
        .ctrl (ctrl)
    );

    mac_product #(.DATA_W(DATA_W)) u_mul (
        .mul_a    (src_a),
        .mul_b    (src_b),
        .zero_ext (ctrl.zero_ext),
        .product  (product)
    );

    mac_combine #(.DATA_W(DATA_W)) u_acc (
        .acc_now  ({hi_q, lo_q}),
        .product  (product),
        .ctrl     (ctrl),
        .acc_next (acc_next)
    );

    assign commit = op_valid & ~ctrl.illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            done_q <= op_valid;
            ill_q  <= op_valid & ctrl.illegal;
            if (commit) begin
                hi_q  <= acc_next[ACC_W-1:DATA_W];
                lo_q  <= acc_next[DATA_W-1:0];
                res_q <= ctrl.ret_hi ? acc_next[ACC_W-1:DATA_W] : acc_next[DATA_W-1:0];
            end else begin
                if (hi_we) hi_q <= hi_wdata;
                if (lo_we) lo_q <= lo_wdata;
                if (op_valid) res_q <= '0;
            end
        end
    end

    assign hi_rdata    = hi_q;
    assign lo_rdata    = lo_q;
    assign res_data    = res_q;
    assign res_done    = done_q;
    assign res_illegal = ill_q;

endmodule

// File: rtl/hilo_mac_checks.sv
module hilo_mac_checks #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic              hi_we,
    input logic [DATA_W-1:0] hi_wdata,
    input logic              lo_we,
    input logic [DATA_W-1:0] lo_wdata,
    input logic [DATA_W-1:0] hi_rdata,
    input logic [DATA_W-1:0] lo_rdata,
    input logic [DATA_W-1:0] res_data,
    input logic              res_done,
    input logic              res_illegal
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d) begin
            p_reset_clear_r1: assert (hi_rdata == '0 && lo_rdata == '0 && !res_done && !res_illegal)
                else $error("reset did not clear state");
        end
    end

    p_done_follows_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_done);

    p_no_stray_done_r8: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_done);

    p_result_half_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[3:1] != 3'd7) |=>
        (res_data == (($past(op_sel[3:1]) >= 3'd3) ? hi_rdata : lo_rdata)));

    p_reserved_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[3:1] == 3'd7 && !hi_we && !lo_we) |=>
        ($stable(hi_rdata) && $stable(lo_rdata) && res_illegal && res_data == '0));

    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && hi_we && lo_we) |=>
        (hi_rdata == $past(hi_wdata) && lo_rdata == $past(lo_wdata)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !hi_we && !lo_we) |=> ($stable(hi_rdata) && $stable(lo_rdata)));

endmodule

bind hilo_mac_unit hilo_mac_checks #(.DATA_W(DATA_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .hi_we       (hi_we),
    .hi_wdata    (hi_wdata),
    .lo_we       (lo_we),
    .lo_wdata    (lo_wdata),
    .hi_rdata    (hi_rdata),
    .lo_rdata    (lo_rdata),
    .res_data    (res_data),
    .res_done    (res_done),
    .res_illegal (res_illegal)
);

// File: tb/hilo_mac_unit_test.sv
module hilo_mac_unit_test;

    typedef struct {
        logic [31:0] data;
        logic        ill;
        logic [31:0] hi;
        logic [31:0] lo;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        hi_we = 1'b0;
    logic [31:0] hi_wdata = '0;
    logic        lo_we = 1'b0;
    logic [31:0] lo_wdata = '0;
    logic [31:0] hi_rdata, lo_rdata, res_data;
    logic        res_done, res_illegal;

    int errors = 0;
    int checks = 0;
    exp_t q[$];
    logic [63:0] model = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    hilo_mac_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .hi_we(hi_we), .hi_wdata(hi_wdata),
        .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_rdata(hi_rdata),
        .lo_rdata(lo_rdata), .res_data(res_data), .res_done(res_done),
        .res_illegal(res_illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic uns);
        longint pa, pb;
        if (uns) begin
            pa = longint'({32'h0, a});
            pb = longint'({32'h0, b});
        end else begin
            pa = longint'(int'(a));
            pb = longint'(int'(b));
        end
        return 64'(pa * pb);
    endfunction

    // Driver: called at a falling edge, leaves the request up for one cycle
    task automatic issue(input logic [3:0] sel, input logic [31:0] a, input logic [31:0] b,
                         input string tag, input logic wr_hi = 1'b0, input logic [31:0] wd = '0);
        exp_t e;
        logic [63:0] p;
        logic [2:0]  k;
        k = sel[3:1];
        p = ref_prod(a, b, sel[0]);
        e.ill = (k == 3'd7);
        e.tag = tag;
        case (k)
            3'd0, 3'd4: model = 64'd0 - p;
            3'd1, 3'd5: model = model + p;
            3'd2, 3'd6: model = model - p;
            3'd3:       model = p;
            default:    if (wr_hi) model[63:32] = wd;
        endcase
        e.hi = model[63:32];
        e.lo = model[31:0];
        e.data = e.ill ? 32'h0 : ((k >= 3'd3) ? model[63:32] : model[31:0]);
        q.push_back(e);
        op_valid = 1'b1; op_sel = sel; src_a = a; src_b = b;
        hi_we = wr_hi; hi_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0; hi_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_both(input logic [31:0] h, input logic [31:0] l);
        hi_we = 1'b1; hi_wdata = h; lo_we = 1'b1; lo_wdata = l;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
        model = {h, l};
        check("R10 hi write", {32'h0, hi_rdata}, {32'h0, h});
        check("R10 lo write", {32'h0, lo_rdata}, {32'h0, l});
    endtask

    // Monitor: compares each result against the queued expectation
    always @(negedge clk) begin
        if (!rst && res_done) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8: done with no request pending actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " res_data"}, {32'h0, res_data}, {32'h0, e.data});
                check({e.tag, " illegal R9"}, {63'h0, res_illegal}, {63'h0, e.ill});
                check({e.tag, " hilo"}, {hi_rdata, lo_rdata}, {e.hi, e.lo});
            end
        end
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hi after reset", {32'h0, hi_rdata}, 64'h0);
        check("R1 lo after reset", {32'h0, lo_rdata}, 64'h0);
        check("R1 done after reset", {63'h0, res_done}, 64'h0);
        rst = 1'b0;
        idle(2);
        check("R8 no done while idle", {63'h0, res_done}, 64'h0);

        issue(4'b0110, 32'hFFFF_FFFD, 32'd7, "R6 R2 signed product");
        idle(1);
        issue(4'b0111, 32'hFFFF_FFFD, 32'd7, "R6 R2 unsigned product");
        idle(1);
        issue(4'b0010, 32'd5, 32'd6, "R4 R7 accumulate lo");
        idle(1);
        issue(4'b1011, 32'h8000_0000, 32'h8000_0000, "R4 R7 accumulate hi unsigned");
        idle(1);
        issue(4'b0100, 32'hFFFF_FFFF, 32'd9, "R5 subtract lo signed");
        idle(1);
        issue(4'b1101, 32'h1234_5678, 32'h9ABC_DEF0, "R5 subtract hi unsigned");
        idle(1);
        issue(4'b0000, 32'd3, 32'hFFFF_FFFE, "R3 negate lo signed");
        idle(1);
        issue(4'b0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 negate lo unsigned");
        idle(1);
        issue(4'b1000, 32'd100, 32'd200, "R3 R7 negate hi");
        idle(1);
        issue(4'b1001, 32'h0000_0000, 32'h7777_7777, "R3 negate zero unsigned");
        idle(1);

        write_both(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue(4'b0011, 32'd1, 32'd1, "R11 wrap to zero");
        idle(1);
        issue(4'b0100, 32'd1, 32'd1, "R11 wrap below zero");
        idle(1);

        // back-to-back chain
        issue(4'b0110, 32'd10, 32'd10, "R8 chain start");
        issue(4'b0010, 32'd7, 32'd3, "R8 chain acc");
        issue(4'b1010, 32'hFFFF_FFFF, 32'd4, "R8 chain acc hi");
        issue(4'b1100, 32'd2, 32'd50, "R8 chain sub hi");
        issue(4'b0101, 32'hF000_0000, 32'h10, "R8 chain sub unsigned");
        idle(2);

        issue(4'b1110, 32'd9, 32'd9, "R9 reserved signed");
        idle(1);
        issue(4'b1111, 32'd5, 32'd5, "R9 reserved unsigned");
        idle(1);
        issue(4'b1110, 32'd1, 32'd1, "R9 reserved with write", 1'b1, 32'hCAFE_0001);
        idle(1);

        write_both(32'h0000_0001, 32'h0000_0002);
        issue(4'b0010, 32'd4, 32'd4, "R10 op beats write", 1'b1, 32'hDEAD_BEEF);
        idle(1);
        check("R10 hi after contested write", {32'h0, hi_rdata}, {32'h0, model[63:32]});

        idle(3);
        check("R8 queue drained", 64'(q.size()), 64'h0);
        finished = 1;
        report();
    end

endmodule